// File: doc/BRIEF.md
# Single-Precision Float Min/Max Unit

This block picks the larger or the smaller of two single-precision floating-point values. It works only on the raw 32-bit patterns and needs no floating-point datapath. The ordering is sign-magnitude, so the infinities sit at the two ends and subnormals are ordered like any other value. Operands that are numerically equal are merged bit by bit, which fixes the sign of a zero result. NaN operands follow fixed rules, and a signaling NaN raises an invalid-operation flag.

The unit is purely combinational. A surrounding pipeline samples the result and the flag in the same cycle in which it applies the operands. One select input chooses between maximum and minimum.

Top module: `fp_minmax_unit`

## Requirements
- R1: In maximum mode (select = 0), with two non-NaN operands that are not numerically equal, the output is the operand with the greater value under sign-magnitude ordering. Negative values rank below positive ones, and a negative value with a larger magnitude ranks lower.
- R2: In minimum mode (select = 1), with two non-NaN operands that are not numerically equal, the output is the operand with the lesser value.
- R3: Numerically equal operands produce their bitwise AND in maximum mode and their bitwise OR in minimum mode. Both zeros (0x00000000 and 0x80000000) count as equal, so max(+0,-0) = 0x00000000 and min(+0,-0) = 0x80000000.
- R4: A value is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero. When exactly one operand is a NaN, the other operand is output unchanged, in either mode.
- R5: When both operands are NaNs, the output is 0xFFFFFFFF.
- R6: The invalid flag is 1 exactly when at least one operand is a NaN with bit 22 clear (signaling). Quiet NaNs (bit 22 set) and non-NaN values leave it at 0.
- R7: An infinity (exponent all ones, mantissa zero) is not a NaN. +Inf (0x7F800000) ranks above every finite value, and -Inf (0xFF800000) ranks below every finite value.
- R8: The result and the flag depend only on the present inputs and follow an input change without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand, single-precision bit pattern |
| opb_i | input | 32 | Second operand, single-precision bit pattern |
| sel_min_i | input | 1 | 0 selects maximum, 1 selects minimum |
| res_o | output | 32 | Selected or merged result |
| invalid_o | output | 1 | Invalid-operation flag (signaling NaN seen) |

## Verification
Two functions can act in the same evaluation: the invalid flag and the NaN pass-through or canonicalisation of the result. A signaling NaN paired with an ordinary number must raise the flag and return the number in the same cycle. A signaling NaN paired with a quiet NaN must raise the flag and return the all-ones pattern. Vectors that combine these cases are applied, and both outputs are compared at once against values worked out by hand from the requirements. This shows that the flag does not depend on which operand was chosen.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  typedef enum logic {
    PICK_MAX = 1'b0,
    PICK_MIN = 1'b1
  } pick_e;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23,
  localparam int W     = 1 + EXP_W + MANT_W
) (
  input  logic [W-1:0] op_i,
  output logic         nan_o,
  output logic         snan_o,
  output logic         zero_o,
  output logic [W-1:0] key_o
);
  function automatic logic f_is_nan(input logic [W-1:0] v);
    return (&v[W-2:MANT_W]) && (|v[MANT_W-1:0]);
  endfunction

  // Map sign-magnitude onto an unsigned total order: negatives are
  // inverted, positives get the top bit set.
  function automatic logic [W-1:0] f_order_key(input logic [W-1:0] v);
    logic [W-1:0] top;
    top = '0;
    top[W-1] = 1'b1;
    return v[W-1] ? ~v : (v | top);
  endfunction

  assign nan_o  = f_is_nan(op_i);
  assign snan_o = nan_o && !op_i[MANT_W-1];
  assign zero_o = (op_i[W-2:0] == '0);
  assign key_o  = f_order_key(op_i);
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] key_a_i,
  input  logic [W-1:0] key_b_i,
  input  logic         zero_a_i,
  input  logic         zero_b_i,
  output logic         a_gt_b_o,
  output logic         equal_o
);
  assign equal_o  = (key_a_i == key_b_i) || (zero_a_i && zero_b_i);
  assign a_gt_b_o = (key_a_i > key_b_i);
endmodule

// File: rtl/fmm_select.sv
module fmm_select
  import fmm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  pick_e        mode_i,
  input  logic         nan_a_i,
  input  logic         nan_b_i,
  input  logic         a_gt_b_i,
  input  logic         equal_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    if (nan_a_i && nan_b_i) begin
      res_o = '1;
    end else if (nan_a_i) begin
      res_o = b_i;
    end else if (nan_b_i) begin
      res_o = a_i;
    end else if (equal_i) begin
      res_o = (mode_i == PICK_MAX) ? (a_i & b_i) : (a_i | b_i);
    end else if (mode_i == PICK_MAX) begin
      res_o = a_gt_b_i ? a_i : b_i;
    end else begin
      res_o = a_gt_b_i ? b_i : a_i;
    end
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23,
  localparam int W     = 1 + EXP_W + MANT_W,
  localparam int N_OPS = 2
) (
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic        sel_min_i,
  output logic [31:0] res_o,
  output logic        invalid_o
);
  logic [W-1:0] ops   [N_OPS];
  logic [W-1:0] keys  [N_OPS];
  logic         nans  [N_OPS];
  logic         snans [N_OPS];
  logic         zeros [N_OPS];

  // Named internal events, visible to the bound checker.
  logic  a_gt_b;
  logic  ops_equal;
  pick_e mode;

  assign ops[0] = opa_i[W-1:0];
  assign ops[1] = opb_i[W-1:0];
  assign mode   = sel_min_i ? PICK_MIN : PICK_MAX;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) cls_i (
      .op_i   (ops[g]),
      .nan_o  (nans[g]),
      .snan_o (snans[g]),
      .zero_o (zeros[g]),
      .key_o  (keys[g])
    );
  end

  fmm_order #(.W(W)) ord_i (
    .key_a_i  (keys[0]),
    .key_b_i  (keys[1]),
    .zero_a_i (zeros[0]),
    .zero_b_i (zeros[1]),
    .a_gt_b_o (a_gt_b),
    .equal_o  (ops_equal)
  );

  fmm_select #(.W(W)) sel_i (
    .a_i      (ops[0]),
    .b_i      (ops[1]),
    .mode_i   (mode),
    .nan_a_i  (nans[0]),
    .nan_b_i  (nans[1]),
    .a_gt_b_i (a_gt_b),
    .equal_i  (ops_equal),
    .res_o    (res_o)
  );

  assign invalid_o = snans[0] || snans[1];
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker (
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic        sel_min_i,
  input logic [31:0] res_o,
  input logic        invalid_o,
  input logic        ops_equal
);
  logic a_nan, b_nan, a_sig, b_sig, a_zero, b_zero;
  assign a_nan  = (opa_i[30:23] == 8'hFF) && (opa_i[22:0] != 23'd0);
  assign b_nan  = (opb_i[30:23] == 8'hFF) && (opb_i[22:0] != 23'd0);
  assign a_sig  = a_nan && (opa_i[22] == 1'b0);
  assign b_sig  = b_nan && (opb_i[22] == 1'b0);
  assign a_zero = (opa_i[30:0] == 31'd0);
  assign b_zero = (opb_i[30:0] == 31'd0);

  always_comb begin
    p_both_nan_canon_r5: assert (!(a_nan && b_nan) || res_o == 32'hFFFF_FFFF);
    p_single_nan_pass_r4: assert (!(a_nan ^ b_nan) || res_o == (a_nan ? opb_i : opa_i));
    p_invalid_flag_r6: assert (invalid_o == (a_sig || b_sig));
    p_result_is_input_r1: assert (a_nan || b_nan || (a_zero && b_zero) ||
                                  res_o == opa_i || res_o == opb_i);
    p_zero_sign_r3: assert (!(a_zero && b_zero && !a_nan && !b_nan) ||
                            (res_o[31] == (sel_min_i ? (opa_i[31] | opb_i[31])
                                                     : (opa_i[31] & opb_i[31]))));
    p_equal_flag_r3: assert (!(opa_i == opb_i) || ops_equal);
  end
endmodule

bind fp_minmax_unit fmm_checker chk_i (
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .sel_min_i (sel_min_i),
  .res_o     (res_o),
  .invalid_o (invalid_o),
  .ops_equal (ops_equal)
);

// File: tb/fp_minmax_unit_tb_top.sv
module fp_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa, opb;
  logic        sel_min;
  logic [31:0] res;
  logic        inv;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  fp_minmax_unit dut_i (
    .opa_i     (opa),
    .opb_i     (opb),
    .sel_min_i (sel_min),
    .res_o     (res),
    .invalid_o (inv)
  );

  // {req[3:0], a, b, sel_min, expected result, expected flag}
  localparam int NV = 17;
  localparam logic [101:0] VEC [NV] = '{
    {4'd1, 32'h3F80_0000, 32'h4000_0000, 1'b0, 32'h4000_0000, 1'b0}, // R1
    {4'd2, 32'h3F80_0000, 32'h4000_0000, 1'b1, 32'h3F80_0000, 1'b0}, // R2
    {4'd1, 32'hBF80_0000, 32'hC040_0000, 1'b0, 32'hBF80_0000, 1'b0}, // R1
    {4'd2, 32'hBF80_0000, 32'hC040_0000, 1'b1, 32'hC040_0000, 1'b0}, // R2
    {4'd1, 32'hBF80_0000, 32'h3F80_0000, 1'b0, 32'h3F80_0000, 1'b0}, // R1
    {4'd3, 32'h0000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R3
    {4'd3, 32'h0000_0000, 32'h8000_0000, 1'b1, 32'h8000_0000, 1'b0}, // R3
    {4'd3, 32'h8000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R3
    {4'd7, 32'h7F80_0000, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000, 1'b0}, // R7
    {4'd7, 32'hFF80_0000, 32'hFF7F_FFFF, 1'b1, 32'hFF80_0000, 1'b0}, // R7
    {4'd4, 32'h7FC0_0000, 32'h3F80_0000, 1'b0, 32'h3F80_0000, 1'b0}, // R4
    {4'd4, 32'hBF80_0000, 32'hFFC0_0001, 1'b1, 32'hBF80_0000, 1'b0}, // R4
    {4'd6, 32'h7F80_0001, 32'h4000_0000, 1'b1, 32'h4000_0000, 1'b1}, // R6
    {4'd6, 32'h7FC0_0000, 32'hFF80_0005, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R6
    {4'd5, 32'h7FC0_0000, 32'h7FC0_0000, 1'b1, 32'hFFFF_FFFF, 1'b0}, // R5
    {4'd1, 32'h0000_0001, 32'h8000_0001, 1'b0, 32'h0000_0001, 1'b0}, // R1
    {4'd3, 32'h4000_0000, 32'h4000_0000, 1'b1, 32'h4000_0000, 1'b0}  // R3
  };

  task automatic check(input int req, input logic [31:0] exp_res, input logic exp_inv);
    checks++;
    if (res !== exp_res || inv !== exp_inv) begin
      errors++;
      $display("FAIL R%0d: a=%h b=%h min=%0b got res=%h inv=%0b expected res=%h inv=%0b",
               req, opa, opb, sel_min, res, inv, exp_res, exp_inv);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic m);
    @(negedge clk);
    opa = a; opb = b; sel_min = m;
    #1;
  endtask

  initial begin
    opa = '0; opb = '0; sel_min = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Quiescent state: two +0 operands, max mode -> +0, no flag (R3, R6)
    @(negedge clk);
    check(3, 32'h0000_0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][97:66], VEC[i][65:34], VEC[i][33]);
      check(int'(VEC[i][101:98]), VEC[i][32:1], VEC[i][0]);
    end

    // R8: output follows an input change with no clock edge in between
    apply(32'h4000_0000, 32'h3F80_0000, 1'b0);
    check(8, 32'h4000_0000, 1'b0);
    #1 sel_min = 1'b1;
    #1 check(8, 32'h3F80_0000, 1'b0);
    #1 opb = 32'h7F80_0002;
    #1 check(8, 32'h4000_0000, 1'b1);

    // R6: signaling NaN in the second slot with a +Inf partner, min mode
    apply(32'h7F80_0000, 32'hFF80_0001, 1'b1);
    check(6, 32'h7F80_0000, 1'b1);
    // R7: -Inf vs most negative finite in max mode
    apply(32'hFF80_0000, 32'hFF7F_FFFF, 1'b0);
    check(7, 32'hFF7F_FFFF, 1'b0);
    // R5: two signaling NaNs -> canonical all ones, flag set
    apply(32'h7F80_0001, 32'hFF80_0001, 1'b0);
    check(5, 32'hFFFF_FFFF, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule